// File: doc/BRIEF.md
# Register Rename Map with Deferred Free-List Return

This block is the rename stage of an out-of-order core that handles one instruction per cycle. It translates 32 architectural register numbers into 40 physical register numbers. Each request carries two source register numbers and one destination register number. The two sources are looked up in a speculative map. The destination receives a fresh physical register taken from the head of a circular free list. The renamed result appears combinationally in the same cycle as the request, and the map and queue state change at the next clock edge.

The physical register displaced by a destination is not freed at once. It is parked in an in-order pending queue, together with the architectural number and the newly allocated physical register. When a commit pulse retires the oldest pending instruction, its displaced register is appended to the tail of the free list. The new mapping is also written into a committed copy of the map. A flush makes the speculative map equal to the committed copy and hands every still-pending allocation back to the free list. This lets the pipeline restart from a precise state.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and the free list holds physical registers 32 to 39, with 32 at the head, so that 32 is allocated first.
- R2: Both source ports return the speculative mapping as it stands before the current request's destination is remapped. A source equal to the destination therefore returns the mapping held before this request.
- R3: An accepted request receives the head of the free list as its destination register, and `rn_prev_phys` reports the mapping it displaces. Later requests see the new mapping.
- R4: When `rn_valid` is high, `flush` is low and the free list is empty, `rn_stall` is high and `rn_ok` is low. Neither the map nor the free list changes.
- R5: A commit pulse retires the oldest pending rename. It writes that rename's new mapping into the committed map and appends its displaced register to the free-list tail. The free list hands out registers strictly first-in first-out.
- R6: A commit pulse while no rename is pending has no effect.
- R7: A rename and a commit in the same cycle both take effect. The total of free plus pending registers stays at 8, with no entry lost or duplicated.
- R8: A flush copies the committed map into the speculative map. It also appends the new registers of all pending renames to the free-list tail, oldest first, and empties the pending queue. A rename request in the flush cycle is dropped, with `rn_ok` and `rn_stall` both low.
- R9: A commit that arrives together with a flush is applied first. Its mapping becomes part of the restored map, and its displaced register is appended before the flushed allocations.
- R10: At every point, the number of free registers plus the number of pending renames equals 8. After a flush, exactly as many renames are accepted as there are free registers before the stall asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rn_valid | input | 1 | Rename request present |
| rn_src_a | input | 5 | First source architectural register |
| rn_src_b | input | 5 | Second source architectural register |
| rn_dst | input | 5 | Destination architectural register |
| commit | input | 1 | Retire the oldest pending rename |
| flush | input | 1 | Restore committed state and discard in-flight renames |
| rn_ok | output | 1 | Request accepted this cycle |
| rn_stall | output | 1 | Request refused because the free list is empty |
| rn_src_a_phys | output | 6 | Physical register for the first source |
| rn_src_b_phys | output | 6 | Physical register for the second source |
| rn_dst_phys | output | 6 | Newly allocated physical register for the destination |
| rn_prev_phys | output | 6 | Physical register displaced by the destination |

## Verification
The functions that can land in one cycle are allocation at the free-list head and release at its tail, and also a commit together with a flush. The bench drives a rename and a commit in the same cycle in two cases: once with registers still free, and once with the free list empty, where the rename must stall while the commit still releases a register. It also raises commit together with flush while several renames are in flight. Each outcome is judged by the registers handed out on the following renames and by the source mappings read back afterwards, compared against a queue model built from the requirements.

// File: rtl/rn_pkg.sv
package rn_pkg;

  localparam int unsigned ARCH_REGS_DEF = 32;
  localparam int unsigned PHYS_REGS_DEF = 40;

  // circular pointer advance for a ring of arbitrary depth
  function automatic int unsigned ring_add(int unsigned base, int unsigned step,
                                           int unsigned depth);
    return (base + step) % depth;
  endfunction

  // physical register placed in free-list slot s at reset
  function automatic int unsigned reset_free_reg(int unsigned slot, int unsigned arch_regs);
    return arch_regs + slot;
  endfunction

endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned NA = 32,
  parameter int unsigned PW = 6,
  localparam int unsigned AW = $clog2(NA)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a,
  input  logic [AW-1:0] rd_b,
  input  logic [AW-1:0] rd_d,
  output logic [PW-1:0] rdata_a,
  output logic [PW-1:0] rdata_b,
  output logic [PW-1:0] rdata_d,
  input  logic          spec_we,
  input  logic [AW-1:0] spec_waddr,
  input  logic [PW-1:0] spec_wdata,
  input  logic          comm_we,
  input  logic [AW-1:0] comm_waddr,
  input  logic [PW-1:0] comm_wdata,
  input  logic          restore
);

  logic [NA-1:0][PW-1:0] spec_q;
  logic [NA-1:0][PW-1:0] comm_q;

  // reads see the state before this cycle's write
  assign rdata_a = spec_q[rd_a];
  assign rdata_b = spec_q[rd_b];
  assign rdata_d = spec_q[rd_d];

  for (genvar i = 0; i < NA; i++) begin : g_entry
    logic          comm_hit;
    logic [PW-1:0] comm_next;
    assign comm_hit  = comm_we && (comm_waddr == AW'(i));
    assign comm_next = comm_hit ? comm_wdata : comm_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        comm_q[i] <= PW'(i);
        spec_q[i] <= PW'(i);
      end else begin
        comm_q[i] <= comm_next;
        if (restore)
          spec_q[i] <= comm_next;
        else if (spec_we && (spec_waddr == AW'(i)))
          spec_q[i] <= spec_wdata;
      end
    end
  end

  p_restore_copies_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (restore && !comm_we) |=> (spec_q == comm_q));

  p_commit_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    comm_we |=> (comm_q[$past(comm_waddr)] == $past(comm_wdata)));

endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int unsigned NA    = 32,
  parameter int unsigned PW    = 6,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pop,
  input  logic                     push,
  input  logic [PW-1:0]            push_val,
  input  logic                     restore_en,
  input  logic [CW-1:0]            restore_cnt,
  input  logic [DEPTH-1:0][PW-1:0] restore_vals,
  output logic [PW-1:0]            head_val,
  output logic [CW-1:0]            count
);

  logic [DEPTH-1:0][PW-1:0] mem_q, mem_d;
  logic [PTRW-1:0]          head_q, head_d, tail_q, tail_d, tail_one;
  logic [CW-1:0]            count_q, count_d;

  assign head_val = mem_q[head_q];
  assign count    = count_q;

  always_comb begin
    mem_d    = mem_q;
    tail_one = tail_q;
    if (push) begin
      mem_d[tail_q] = push_val;
      tail_one      = PTRW'(rn_pkg::ring_add(tail_q, 1, DEPTH));
    end
    tail_d = tail_one;
    if (restore_en) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (k < int'(restore_cnt))
          mem_d[PTRW'(rn_pkg::ring_add(tail_one, k, DEPTH))] = restore_vals[k];
      end
      tail_d = PTRW'(rn_pkg::ring_add(tail_one, restore_cnt, DEPTH));
    end
    head_d  = pop ? PTRW'(rn_pkg::ring_add(head_q, 1, DEPTH)) : head_q;
    count_d = count_q - CW'(pop) + CW'(push) + (restore_en ? restore_cnt : CW'(0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++)
        mem_q[s] <= PW'(rn_pkg::reset_free_reg(s, NA));
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= CW'(DEPTH);
    end else begin
      mem_q   <= mem_d;
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  p_pop_has_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count_q != '0));

  p_no_pop_in_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |-> !pop);

  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

endmodule

// File: rtl/rn_pend_queue.sv
module rn_pend_queue #(
  parameter int unsigned AW    = 5,
  parameter int unsigned PW    = 6,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [AW-1:0]            push_arch,
  input  logic [PW-1:0]            push_new,
  input  logic [PW-1:0]            push_old,
  input  logic                     pop,
  input  logic                     clear,
  output logic [AW-1:0]            head_arch,
  output logic [PW-1:0]            head_new,
  output logic [PW-1:0]            head_old,
  output logic [CW-1:0]            count,
  output logic [DEPTH-1:0][PW-1:0] ord_new
);

  logic [DEPTH-1:0][AW-1:0] arch_q;
  logic [DEPTH-1:0][PW-1:0] new_q;
  logic [DEPTH-1:0][PW-1:0] old_q;
  logic [PTRW-1:0]          head_q, tail_q;
  logic [CW-1:0]            count_q;

  assign head_arch = arch_q[head_q];
  assign head_new  = new_q[head_q];
  assign head_old  = old_q[head_q];
  assign count     = count_q;

  // entries listed oldest first, for a bulk return on flush
  for (genvar k = 0; k < DEPTH; k++) begin : g_ord
    assign ord_new[k] = new_q[PTRW'(rn_pkg::ring_add(head_q, k, DEPTH))];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arch_q  <= '0;
      new_q   <= '0;
      old_q   <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (clear) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) begin
        arch_q[tail_q] <= push_arch;
        new_q[tail_q]  <= push_new;
        old_q[tail_q]  <= push_old;
        tail_q         <= PTRW'(rn_pkg::ring_add(tail_q, 1, DEPTH));
      end
      if (pop)
        head_q <= PTRW'(rn_pkg::ring_add(head_q, 1, DEPTH));
      count_q <= count_q + CW'(push) - CW'(pop);
    end
  end

  p_pop_has_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count_q != '0));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((count_q != CW'(DEPTH)) || pop));

  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count_q == '0));

endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit #(
  parameter int unsigned NUM_ARCH = rn_pkg::ARCH_REGS_DEF,
  parameter int unsigned NUM_PHYS = rn_pkg::PHYS_REGS_DEF,
  localparam int unsigned AW      = $clog2(NUM_ARCH),
  localparam int unsigned PW      = $clog2(NUM_PHYS),
  localparam int unsigned SPARE   = NUM_PHYS - NUM_ARCH,
  localparam int unsigned CW      = $clog2(SPARE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rn_valid,
  input  logic [AW-1:0] rn_src_a,
  input  logic [AW-1:0] rn_src_b,
  input  logic [AW-1:0] rn_dst,
  input  logic          commit,
  input  logic          flush,
  output logic          rn_ok,
  output logic          rn_stall,
  output logic [PW-1:0] rn_src_a_phys,
  output logic [PW-1:0] rn_src_b_phys,
  output logic [PW-1:0] rn_dst_phys,
  output logic [PW-1:0] rn_prev_phys
);

  // named internal events
  logic          fl_empty;
  logic          do_rename;
  logic          do_commit;
  logic [CW-1:0] fl_count;
  logic [CW-1:0] pq_count;
  logic [PW-1:0] fl_head;
  logic [AW-1:0] pq_head_arch;
  logic [PW-1:0] pq_head_new;
  logic [PW-1:0] pq_head_old;
  logic [SPARE-1:0][PW-1:0] pq_ord_new;
  logic [SPARE-1:0][PW-1:0] ret_vals;
  logic [CW-1:0] ret_cnt;

  assign fl_empty  = (fl_count == '0);
  assign do_rename = rn_valid && !flush && !fl_empty;
  assign do_commit = commit && (pq_count != '0);

  assign rn_ok       = do_rename;
  assign rn_stall    = rn_valid && !flush && fl_empty;
  assign rn_dst_phys = fl_head;

  // on flush the retiring head (if any) is skipped; the rest return in age order
  assign ret_cnt = pq_count - CW'(do_commit);
  for (genvar k = 0; k < SPARE; k++) begin : g_ret
    if (k + 1 < SPARE) begin : g_shift
      assign ret_vals[k] = do_commit ? pq_ord_new[k+1] : pq_ord_new[k];
    end else begin : g_last
      assign ret_vals[k] = do_commit ? '0 : pq_ord_new[k];
    end
  end

  rn_map_table #(.NA(NUM_ARCH), .PW(PW)) map_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_a       (rn_src_a),
    .rd_b       (rn_src_b),
    .rd_d       (rn_dst),
    .rdata_a    (rn_src_a_phys),
    .rdata_b    (rn_src_b_phys),
    .rdata_d    (rn_prev_phys),
    .spec_we    (do_rename),
    .spec_waddr (rn_dst),
    .spec_wdata (fl_head),
    .comm_we    (do_commit),
    .comm_waddr (pq_head_arch),
    .comm_wdata (pq_head_new),
    .restore    (flush)
  );

  rn_free_list #(.NA(NUM_ARCH), .PW(PW), .DEPTH(SPARE)) free_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pop          (do_rename),
    .push         (do_commit),
    .push_val     (pq_head_old),
    .restore_en   (flush),
    .restore_cnt  (ret_cnt),
    .restore_vals (ret_vals),
    .head_val     (fl_head),
    .count        (fl_count)
  );

  rn_pend_queue #(.AW(AW), .PW(PW), .DEPTH(SPARE)) pend_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (do_rename),
    .push_arch (rn_dst),
    .push_new  (fl_head),
    .push_old  (rn_prev_phys),
    .pop       (do_commit),
    .clear     (flush),
    .head_arch (pq_head_arch),
    .head_new  (pq_head_new),
    .head_old  (pq_head_old),
    .count     (pq_count),
    .ord_new   (pq_ord_new)
  );

  p_conserve_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_count + pq_count) == CW'(SPARE));

  p_stall_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rn_stall |-> !rn_ok);

  p_fresh_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rn_ok |-> (rn_dst_phys != rn_prev_phys));

  p_flush_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!rn_ok && !rn_stall));

  p_overlap_balance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rename && do_commit) |=> (fl_count == $past(fl_count)));

  p_idle_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (pq_count == '0) && !rn_valid && !flush) |=> $stable(fl_count));

endmodule

// File: tb/rename_map_unit_tb_top.sv
module rename_map_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rn_valid, commit, flush;
  logic [4:0] rn_src_a, rn_src_b, rn_dst;
  logic       rn_ok, rn_stall;
  logic [5:0] rn_src_a_phys, rn_src_b_phys, rn_dst_phys, rn_prev_phys;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model
  int spec_m[32];
  int comm_m[32];
  int fq[$];
  int pa[$];
  int pn[$];
  int po[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_map_unit dut_i (
    .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_src_a(rn_src_a),
    .rn_src_b(rn_src_b), .rn_dst(rn_dst), .commit(commit), .flush(flush),
    .rn_ok(rn_ok), .rn_stall(rn_stall), .rn_src_a_phys(rn_src_a_phys),
    .rn_src_b_phys(rn_src_b_phys), .rn_dst_phys(rn_dst_phys), .rn_prev_phys(rn_prev_phys)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin
      spec_m[i] = i;
      comm_m[i] = i;
    end
    fq.delete(); pa.delete(); pn.delete(); po.delete();
    for (int i = 32; i < 40; i++) fq.push_back(i);
  endtask

  // one cycle: drive at negedge, check combinational outputs, advance model at posedge
  task automatic step(bit v, int a, int b, int d, bit c, bit f, string tag);
    bit acc, cm;
    @(negedge clk);
    rn_valid = v; rn_src_a = 5'(a); rn_src_b = 5'(b); rn_dst = 5'(d);
    commit = c; flush = f;
    #1;
    acc = v && !f && (fq.size() > 0);
    cm  = c && (pa.size() > 0);
    if (f) begin
      chk({tag, " flush drops request ok (R8)"}, int'(rn_ok), 0);
      chk({tag, " flush drops request stall (R8)"}, int'(rn_stall), 0);
    end else if (v) begin
      chk({tag, " stall"}, int'(rn_stall), int'(fq.size() == 0));
      chk({tag, " ok"}, int'(rn_ok), int'(acc));
      chk({tag, " src_a"}, int'(rn_src_a_phys), spec_m[a]);
      chk({tag, " src_b"}, int'(rn_src_b_phys), spec_m[b]);
      if (acc) begin
        chk({tag, " dst"}, int'(rn_dst_phys), fq[0]);
        chk({tag, " prev"}, int'(rn_prev_phys), spec_m[d]);
      end
    end else begin
      chk({tag, " idle ok"}, int'(rn_ok), 0);
      chk({tag, " idle stall"}, int'(rn_stall), 0);
    end
    @(posedge clk);
    if (acc) begin
      int np;
      np = fq.pop_front();
      pa.push_back(d); pn.push_back(np); po.push_back(spec_m[d]);
      spec_m[d] = np;
    end
    if (cm) begin
      int ar, n, o;
      ar = pa.pop_front(); n = pn.pop_front(); o = po.pop_front();
      comm_m[ar] = n;
      fq.push_back(o);
    end
    if (f) begin
      foreach (pn[k]) fq.push_back(pn[k]);
      pa.delete(); pn.delete(); po.delete();
      spec_m = comm_m;
    end
  endtask

  task automatic t_reset_r1();
    chk("R1 stall after reset", int'(rn_stall), 0);
    step(1, 7, 31, 3, 0, 0, "R1");
    chk("R1 first allocation", fq.size(), 7);
    step(1, 3, 0, 9, 0, 0, "R1 src_a after remap");
  endtask

  task automatic t_src_order_r2();
    step(1, 3, 9, 3, 0, 0, "R2 same reg");
    step(1, 3, 3, 12, 0, 0, "R2 read new");
  endtask

  task automatic t_chain_r3();
    step(1, 1, 2, 5, 0, 0, "R3");
    step(1, 5, 5, 5, 0, 0, "R3 redefine");
    step(1, 5, 12, 20, 0, 0, "R3 consume");
  endtask

  task automatic t_exhaust_r4();
    while (fq.size() > 0) step(1, 4, 6, 8, 0, 0, "R4 fill");
    step(1, 8, 5, 8, 0, 0, "R4 stalled");
    step(1, 5, 3, 2, 0, 0, "R4 stalled again");
    step(0, 0, 0, 0, 0, 0, "R4 idle");
  endtask

  task automatic t_overlap_r7();
    step(1, 8, 3, 11, 1, 0, "R7 empty list commit");
    step(1, 11, 8, 11, 1, 0, "R7 alloc and release");
    step(1, 11, 2, 14, 1, 0, "R7 alloc and release 2");
    step(1, 14, 11, 1, 0, 0, "R7 after");
  endtask

  task automatic t_commit_r5();
    step(0, 0, 0, 0, 1, 0, "R5 commit");
    step(0, 0, 0, 0, 1, 0, "R5 commit");
    step(1, 2, 3, 4, 0, 0, "R5 fifo alloc");
    step(1, 4, 1, 6, 0, 0, "R5 fifo alloc");
  endtask

  task automatic t_flush_r8();
    step(1, 6, 4, 7, 1, 1, "R8 flush with commit");
    step(1, 4, 6, 7, 0, 0, "R8 map restored");
    step(1, 3, 5, 8, 0, 0, "R8 map restored");
    step(1, 14, 1, 0, 0, 0, "R8 alloc order");
  endtask

  task automatic t_idle_commit_r6();
    step(0, 0, 0, 0, 0, 1, "R6 flush all");
    chk("R6 nothing pending", pa.size(), 0);
    step(0, 0, 0, 0, 1, 0, "R6 empty commit");
    step(1, 7, 8, 9, 1, 0, "R6 alloc unchanged");
  endtask

  task automatic t_flush_commit_r9();
    step(1, 1, 2, 10, 0, 0, "R9 setup");
    step(1, 10, 2, 11, 0, 0, "R9 setup");
    step(1, 11, 10, 10, 0, 0, "R9 setup");
    step(0, 0, 0, 0, 1, 1, "R9 commit+flush");
    step(1, 10, 11, 3, 0, 0, "R9 committed map kept");
    step(1, 9, 1, 4, 0, 0, "R9 order");
  endtask

  task automatic t_capacity_r10();
    int got, expn;
    step(0, 0, 0, 0, 0, 1, "R10 flush");
    expn = fq.size();
    chk("R10 free after flush", expn, 8);
    got = 0;
    for (int i = 0; i < 12; i++) begin
      step(1, i % 32, (i * 3) % 32, (i * 5) % 32, 0, 0, "R10 drain");
      if (rn_ok) got++;
    end
    chk("R10 accepted before stall", got, expn);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rn_valid = 0; commit = 0; flush = 0;
    rn_src_a = 0; rn_src_b = 0; rn_dst = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset_r1();
    t_src_order_r2();
    t_chain_r3();
    t_exhaust_r4();
    t_overlap_r7();
    t_commit_r5();
    t_flush_r8();
    t_idle_commit_r6();
    t_flush_commit_r9();
    t_capacity_r10();
    step(0, 0, 0, 0, 0, 0, "end");
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule